// File: doc/BRIEF.md
# Management Controller Host Register Window (target side)

This block is the controller end of a three-register byte window that a host processor uses to exchange request and response messages with a management controller. The host sees a data register, a control/status register and a flags register on a small byte bus. The host loads a byte and a control code, then sets the busy flag. The target holds busy for a fixed number of cycles and then carries out the control code. It answers with a status code equal to the control code with bit 7 set, and clears busy.

Request bytes go into an internal buffer that can be read out on a local port. The response path is a byte FIFO that local logic fills. The target presents the queued bytes one at a time when the host asks for them. A control code that arrives out of sequence, or a request that overflows the buffer, is reported through the data register as an error code, and the window returns to its ready state.

Top module: `mgmt_win_target`

## Requirements
- R1: After reset the flags register (offset 2) reads 0x00, the status register (offset 1) reads 0xC0 and the data register (offset 0) reads 0x00.
- R2: Writing offset 2 with bit 0 set while not busy sets busy (flags bit 0). Busy reads 1 for exactly BUSY_LAT+1 cycles and then clears. Flags bits 1, 3, 4 and 5 always read 0, so the flags never read 0xFF.
- R3: While busy is set, host writes to all three offsets are ignored, and the command in progress uses the data and control values that were latched before busy rose.
- R4: Write start (0x41) from ready gives status 0xC1, and write next (0x42) in the write phase gives 0xC2. Transmit-ready (flags bit 6) is 1 exactly during the write phase.
- R5: Request bytes are stored in the order the host sends them, from address 0 upward. Write end (0x43) stores the last byte and gives status 0xC3 with data 0x00. It also pulses req_done for one cycle with req_len equal to the byte count.
- R6: If write next or write end arrives when REQ_DEPTH bytes are already stored, the byte is not stored. The result is status 0xC3 with data 0x05 (buffer full), and the window returns to ready.
- R7: A control code that is not valid in the current phase, or that is not in the range 0x40 to 0x46, gives status 0xC0 with data 0x02 (illegal control), and the window returns to ready.
- R8: Receive-ready (flags bit 7) is 1 while a response is awaited or being read and the response FIFO is non-empty. Message-available (flags bit 2) is 1 in the ready phase while the FIFO is non-empty.
- R9: Read start (0x44) after a write end pops the first response byte into data with status 0xC4. Each read next (0x45) pops the next byte, with status 0xC5 if bytes remain and 0xC6 if it was the last one. Read end (0x46) gives status 0xC0 with data 0x00.
- R10: Get status (0x40) in any phase gives status 0xC0 with data 0x00 and abandons a partly written request.
- R11: Read start or read next when the response FIFO is empty is an illegal control (status 0xC0, data 0x02).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset: 0 data, 1 control/status, 2 flags |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| rsp_push | input | 1 | Push one response byte (ignored when full) |
| rsp_byte | input | 8 | Response byte to push |
| rsp_full | output | 1 | Response FIFO full |
| req_rd_addr | input | REQ_AW | Request buffer read address |
| req_rd_byte | output | 8 | Request buffer byte, one cycle after the address |
| req_done | output | 1 | One-cycle pulse when a request completes |
| req_len | output | LEN_W | Byte count of the last completed request |

## Verification
The hardest condition to reach is the buffer-full boundary, which needs exactly REQ_DEPTH stored bytes. The bench gets there by issuing a write start and then looping write-next commands. One run ends with a valid write end at the full length, and two more push one byte beyond it with write next and with write end. The busy-window case is also hard to reach from the ports: the bench issues data, control and flags writes in the cycles right after busy rises and then checks that the original command ran. The rejected control codes are reached by sending read commands with an empty FIFO and write commands from the wrong phase.

// File: rtl/mgmt_win_pkg.sv
package mgmt_win_pkg;
  localparam logic [7:0] CC_GET      = 8'h40;
  localparam logic [7:0] CC_WR_FIRST = 8'h41;
  localparam logic [7:0] CC_WR_MID   = 8'h42;
  localparam logic [7:0] CC_WR_LAST  = 8'h43;
  localparam logic [7:0] CC_RD_FIRST = 8'h44;
  localparam logic [7:0] CC_RD_MID   = 8'h45;
  localparam logic [7:0] CC_RD_LAST  = 8'h46;
  localparam logic [7:0] ST_READY    = 8'hC0;
  localparam logic [7:0] ST_MARK     = 8'h80;

  typedef enum logic [7:0] {
    ERR_NONE     = 8'h00,
    ERR_ABORT    = 8'h01,
    ERR_BAD_CTRL = 8'h02,
    ERR_NO_RESP  = 8'h03,
    ERR_BAD_CMD  = 8'h04,
    ERR_FULL     = 8'h05
  } err_code_e;

  typedef enum logic [1:0] {
    PH_READY   = 2'd0,
    PH_WRITING = 2'd1,
    PH_AWAIT   = 2'd2,
    PH_READING = 2'd3
  } phase_e;
endpackage

// File: rtl/win_busy_timer.sv
module win_busy_timer #(
  parameter int LAT = 3,
  localparam int CW = $clog2(LAT + 1) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire
);
  logic [CW-1:0] cnt;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT);
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R3: the decode must never try to restart a running command
  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/win_req_ram.sv
module win_req_ram #(
  parameter int DEPTH = 80,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/win_rsp_fifo.sv
module win_rsp_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] head,
  output logic       empty,
  output logic       full,
  output logic       one_left
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign one_left = (cnt == CW'(1));
  assign head     = mem[rp];
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/mgmt_win_target.sv
module mgmt_win_target
  import mgmt_win_pkg::*;
#(
  parameter int REQ_DEPTH = 80,
  parameter int RSP_DEPTH = 16,
  parameter int BUSY_LAT  = 3,
  localparam int REQ_AW = $clog2(REQ_DEPTH),
  localparam int LEN_W  = $clog2(REQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              rsp_push,
  input  logic [7:0]        rsp_byte,
  output logic              rsp_full,
  input  logic [REQ_AW-1:0] req_rd_addr,
  output logic [7:0]        req_rd_byte,
  output logic              req_done,
  output logic [LEN_W-1:0]  req_len
);
  logic busy, fire, start, wr_ok;
  logic [7:0] data_in, ctrl_q, status_q, data_out, flags;
  phase_e phase_q;
  logic [LEN_W-1:0] req_cnt;

  phase_e nx_phase;
  logic [7:0] nx_status, nx_dout;
  logic [LEN_W-1:0] nx_cnt;
  logic ram_we, pop, done;
  logic [7:0] head;
  logic empty, one_left, buf_full;

  assign wr_ok    = bus_wr && !busy;
  assign start    = wr_ok && (bus_addr == 2'd2) && bus_wdata[0];
  assign buf_full = (req_cnt == LEN_W'(REQ_DEPTH));

  win_busy_timer #(.LAT(BUSY_LAT)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .fire(fire));

  win_req_ram #(.DEPTH(REQ_DEPTH)) u_req (
    .clk(clk), .we(ram_we), .waddr(REQ_AW'(req_cnt)), .wdata(data_in),
    .raddr(req_rd_addr), .rdata(req_rd_byte));

  win_rsp_fifo #(.DEPTH(RSP_DEPTH)) u_rsp (
    .clk(clk), .rst(rst), .push(rsp_push), .din(rsp_byte), .pop(pop),
    .head(head), .empty(empty), .full(rsp_full), .one_left(one_left));

  // host-side latches for the data and control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      data_in <= '0;
      ctrl_q  <= '0;
    end else if (wr_ok) begin
      if (bus_addr == 2'd0) data_in <= bus_wdata;
      if (bus_addr == 2'd1) ctrl_q  <= bus_wdata;
    end
  end

  // command execution when the busy window ends
  always_comb begin
    nx_phase  = phase_q;
    nx_status = status_q;
    nx_dout   = data_out;
    nx_cnt    = req_cnt;
    ram_we    = 1'b0;
    pop       = 1'b0;
    done      = 1'b0;
    if (fire) begin
      // default outcome: illegal control, back to ready
      nx_status = ST_READY;
      nx_dout   = ERR_BAD_CTRL;
      nx_phase  = PH_READY;
      nx_cnt    = '0;
      unique case (ctrl_q)
        CC_GET: nx_dout = ERR_NONE;
        CC_WR_FIRST: if (phase_q == PH_READY) begin
          ram_we    = 1'b1;
          nx_cnt    = LEN_W'(1);
          nx_status = ctrl_q | ST_MARK;
          nx_dout   = data_out;
          nx_phase  = PH_WRITING;
        end
        CC_WR_MID, CC_WR_LAST: if (phase_q == PH_WRITING) begin
          nx_status = CC_WR_LAST | ST_MARK;
          if (buf_full) begin
            nx_dout = ERR_FULL;
          end else begin
            ram_we = 1'b1;
            nx_cnt = req_cnt + 1'b1;
            if (ctrl_q == CC_WR_MID) begin
              nx_status = ctrl_q | ST_MARK;
              nx_dout   = data_out;
              nx_phase  = PH_WRITING;
            end else begin
              nx_dout  = ERR_NONE;
              nx_phase = PH_AWAIT;
              done     = 1'b1;
            end
          end
        end
        CC_RD_FIRST: if (phase_q == PH_AWAIT && !empty) begin
          pop       = 1'b1;
          nx_dout   = head;
          nx_status = ctrl_q | ST_MARK;
          nx_phase  = PH_READING;
        end
        CC_RD_MID: if (phase_q == PH_READING && !empty) begin
          pop       = 1'b1;
          nx_dout   = head;
          nx_status = one_left ? (CC_RD_LAST | ST_MARK) : (ctrl_q | ST_MARK);
          nx_phase  = PH_READING;
        end
        CC_RD_LAST: if (phase_q == PH_READING) nx_dout = ERR_NONE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_READY;
      status_q <= ST_READY;
      data_out <= '0;
      req_cnt  <= '0;
      req_done <= 1'b0;
      req_len  <= '0;
    end else begin
      phase_q  <= nx_phase;
      status_q <= nx_status;
      data_out <= nx_dout;
      req_cnt  <= nx_cnt;
      req_done <= done;
      if (done) req_len <= nx_cnt;
    end
  end

  assign flags = {((phase_q == PH_AWAIT || phase_q == PH_READING) && !empty),
                  (phase_q == PH_WRITING), 3'b000,
                  (phase_q == PH_READY && !empty), 1'b0, busy};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      unique case (bus_addr)
        2'd0:    bus_rdata <= data_out;
        2'd1:    bus_rdata <= status_q;
        2'd2:    bus_rdata <= flags;
        default: bus_rdata <= 8'h00;
      endcase
    end
  end

  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (rst)
    busy && bus_wr |=> $stable(ctrl_q) && $stable(data_in));
  p_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && phase_q == PH_WRITING |-> status_q == (ctrl_q | ST_MARK));
  p_req_bound_r6: assert property (@(posedge clk) disable iff (rst)
    req_cnt <= LEN_W'(REQ_DEPTH));
  p_ready_after_c0_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && status_q == ST_READY |-> phase_q == PH_READY);
  p_done_once_r5: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);
endmodule

// File: tb/tb_mgmt_win_target.sv
module tb_mgmt_win_target;
  localparam int REQ_DEPTH = 80;
  localparam int RSP_DEPTH = 16;
  localparam int BUSY_LAT  = 3;
  localparam int REQ_AW = $clog2(REQ_DEPTH);
  localparam int LEN_W  = $clog2(REQ_DEPTH + 1);

  logic clk = 0, rst = 1;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, rsp_push = 0;
  logic [7:0] bus_wdata = 0, rsp_byte = 0, bus_rdata, req_rd_byte;
  logic rsp_full, req_done;
  logic [REQ_AW-1:0] req_rd_addr = 0;
  logic [LEN_W-1:0] req_len;

  mgmt_win_target #(.REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH), .BUSY_LAT(BUSY_LAT)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rsp_push(rsp_push), .rsp_byte(rsp_byte),
    .rsp_full(rsp_full), .req_rd_addr(req_rd_addr), .req_rd_byte(req_rd_byte),
    .req_done(req_done), .req_len(req_len));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int done_n = 0, last_len = 0;

  // behavioural reference state
  int m_ph = 0;              // 0 ready, 1 writing, 2 awaiting, 3 reading
  logic [7:0] m_st = 8'hC0, m_dv = 8'h00;
  logic [7:0] m_req[$];
  logic [7:0] m_rsp[$];
  int m_done = 0, m_len = 0;

  always @(negedge clk) if (!rst && req_done) begin done_n++; last_len = int'(req_len); end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic push_rsp(input logic [7:0] b);
    rsp_push = 1; rsp_byte = b;
    @(negedge clk); rsp_push = 0;
    m_rsp.push_back(b);
  endtask

  function automatic logic [7:0] m_flags();
    logic [7:0] f = 8'h00;
    if ((m_ph == 2 || m_ph == 3) && m_rsp.size() > 0) f[7] = 1;
    if (m_ph == 1) f[6] = 1;
    if (m_ph == 0 && m_rsp.size() > 0) f[2] = 1;
    return f;
  endfunction

  task automatic m_bad(input logic [7:0] code);
    m_st = 8'hC0; m_dv = code; m_ph = 0; m_req.delete();
  endtask

  task automatic m_exec(input logic [7:0] c, input logic [7:0] din);
    case (c)
      8'h40: begin m_st = 8'hC0; m_dv = 8'h00; m_ph = 0; m_req.delete(); end
      8'h41: if (m_ph == 0) begin m_req.delete(); m_req.push_back(din); m_st = 8'hC1; m_ph = 1; end
             else m_bad(8'h02);
      8'h42, 8'h43: if (m_ph != 1) m_bad(8'h02);
             else if (m_req.size() == REQ_DEPTH) begin m_bad(8'h05); m_st = 8'hC3; end
             else begin
               m_req.push_back(din);
               if (c == 8'h42) m_st = 8'hC2;
               else begin m_st = 8'hC3; m_dv = 8'h00; m_ph = 2; m_done++; m_len = m_req.size(); end
             end
      8'h44: if (m_ph == 2 && m_rsp.size() > 0) begin m_dv = m_rsp.pop_front(); m_st = 8'hC4; m_ph = 3; end
             else m_bad(8'h02);
      8'h45: if (m_ph == 3 && m_rsp.size() > 0) begin
               m_dv = m_rsp.pop_front(); m_st = (m_rsp.size() == 0) ? 8'hC6 : 8'hC5;
             end else m_bad(8'h02);
      8'h46: if (m_ph == 3) begin m_st = 8'hC0; m_dv = 8'h00; m_ph = 0; end
             else m_bad(8'h02);
      default: m_bad(8'h02);
    endcase
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] f;
    n = 0;
    do begin bus_read(2'd2, f); if (f[0]) n++; end while (f[0] && n < 1000);
  endtask

  task automatic compare(input string tag);
    logic [7:0] v;
    bus_read(2'd1, v); check({tag, " status"}, v, m_st);
    bus_read(2'd0, v); check({tag, " data"}, v, m_dv);
    bus_read(2'd2, v); check("R8 flags", v, m_flags());
  endtask

  task automatic cmd(input logic [7:0] c, input logic [7:0] din, input string tag);
    int n;
    bus_write(2'd0, din); bus_write(2'd1, c); bus_write(2'd2, 8'h01);
    wait_idle(n);
    check("R2 busy length", n, BUSY_LAT + 1);
    m_exec(c, din);
    compare(tag);
  endtask

  task automatic req_byte(input int a, input int exp, input string tag);
    req_rd_addr = REQ_AW'(a);
    @(negedge clk); @(negedge clk);
    check(tag, req_rd_byte, exp);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    bus_read(2'd2, v); check("R1 flags", v, 8'h00);
    bus_read(2'd1, v); check("R1 status", v, 8'hC0);
    bus_read(2'd0, v); check("R1 data", v, 8'h00);

    cmd(8'h40, 8'h00, "R2 get");

    // R3: writes during busy are ignored
    bus_write(2'd0, 8'hAA); bus_write(2'd1, 8'h41); bus_write(2'd2, 8'h01);
    bus_write(2'd0, 8'h55); bus_write(2'd1, 8'h4F); bus_write(2'd2, 8'h01);
    wait_idle(n);
    m_exec(8'h41, 8'hAA);
    compare("R3");
    // R4/R5 write phase
    cmd(8'h42, 8'h11, "R4");
    cmd(8'h42, 8'h22, "R4");
    cmd(8'h43, 8'h33, "R5");
    check("R5 done count", done_n, m_done);
    check("R5 length", last_len, 4);
    req_byte(0, 8'hAA, "R3 byte0");
    req_byte(1, 8'h11, "R5 byte1");
    req_byte(3, 8'h33, "R5 byte3");

    // R8/R9 response
    bus_read(2'd2, v); check("R8 no rx", v, 8'h00);
    push_rsp(8'h20); push_rsp(8'h21); push_rsp(8'h22);
    @(negedge clk);
    bus_read(2'd2, v); check("R8 rx", v, 8'h80);
    cmd(8'h44, 8'h00, "R9 start");
    cmd(8'h45, 8'h00, "R9 next");
    cmd(8'h45, 8'h00, "R9 last");
    cmd(8'h46, 8'h00, "R9 end");

    // R11 empty FIFO
    cmd(8'h41, 8'h01, "R4");
    cmd(8'h43, 8'h02, "R5");
    cmd(8'h44, 8'h00, "R11 start empty");
    cmd(8'h41, 8'h03, "R4");
    cmd(8'h43, 8'h04, "R5");
    push_rsp(8'h30); push_rsp(8'h31);
    cmd(8'h44, 8'h00, "R9 start");
    cmd(8'h45, 8'h00, "R9 last");
    cmd(8'h45, 8'h00, "R11 next empty");

    // R8 message available, R10 keeps FIFO
    push_rsp(8'h40);
    @(negedge clk);
    bus_read(2'd2, v); check("R8 msg", v, 8'h04);

    // R7 out of sequence / unknown
    cmd(8'h42, 8'h00, "R7 next in ready");
    cmd(8'h47, 8'h00, "R7 unknown");
    cmd(8'h00, 8'h00, "R7 zero");
    cmd(8'h46, 8'h00, "R7 end in ready");

    // R10 abort
    cmd(8'h41, 8'h05, "R4");
    cmd(8'h42, 8'h06, "R4");
    cmd(8'h40, 8'h00, "R10 get");
    cmd(8'h42, 8'h07, "R10 after abort");

    // R6 full length accepted
    cmd(8'h41, 8'h00, "R4");
    for (int i = 1; i < REQ_DEPTH - 1; i++) cmd(8'h42, 8'(i), "R4");
    cmd(8'h43, 8'(REQ_DEPTH - 1), "R6 exact fit");
    check("R6 length", last_len, REQ_DEPTH);
    req_byte(REQ_DEPTH - 1, REQ_DEPTH - 1, "R6 last byte");
    cmd(8'h44, 8'h00, "R9 leftover");
    cmd(8'h46, 8'h00, "R9 end");

    // R6 overflow by write next and write end
    cmd(8'h41, 8'h00, "R4");
    for (int i = 1; i < REQ_DEPTH; i++) cmd(8'h42, 8'(i), "R4");
    cmd(8'h42, 8'hEE, "R6 next full");
    cmd(8'h41, 8'h00, "R4");
    for (int i = 1; i < REQ_DEPTH; i++) cmd(8'h42, 8'(i), "R4");
    cmd(8'h43, 8'hEE, "R6 end full");
    check("R6 no done", done_n, m_done);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule